// File: doc/BRIEF.md
# Streaming Binary Integral Image Generator

This block turns a raster-ordered stream of single-bit pixels into a stream of integral-image values. For every accepted pixel it emits, one clock later, the number of set pixels inside the rectangle that spans from the frame's top-left corner to the current position, both corners included. It sits between a binarising stage and a box-sum stage. The box-sum stage can then compute any rectangular population count from four lookups.

Internally it holds one line of previously produced integral values and a row accumulator. The row accumulator counts the set pixels from the start of the current row up to and including the present one. Each result is the stored value of the pixel directly above plus that row count. The result is stored back into the same column for the next row. The line store is never swept clean: while the first row of a frame is being processed, its reads are treated as zero. Image width and height are parameters. The result width is the smallest that can hold width times height.

The reset is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `bin_integral_stream`

## Requirements
- R1: For each accepted pixel at column x and row y of the current frame, the output value is the count of set pixels with column <= x and row <= y in that frame.
- R2: `res_vld` is high in exactly the cycles that follow a cycle with `pix_vld` high, so the latency is one clock.
- R3: A cycle with `pix_vld` low advances no position and changes no sum, and `res_val` keeps its previous value.
- R4: A pixel accepted with `pix_sof` high is taken as column 0, row 0 of a new frame, even in the middle of a frame. The contents the line store held from earlier rows are then not used.
- R5: Accepted pixels are placed in raster order: the column rises by one per pixel, and after column IMG_W-1 it returns to 0 on the next row. After the pixel at column IMG_W-1, row IMG_H-1, the next pixel is column 0, row 0 of a new frame whether or not `pix_sof` is set.
- R6: `res_val` is ceil(log2(IMG_W*IMG_H+1)) bits wide. A frame of all ones yields IMG_W*IMG_H on its final pixel, and no output ever exceeds that value.
- R7: `pix_sof` has no effect in a cycle where `pix_vld` is low.
- R8: While reset is asserted and right after it, `res_vld` and `res_val` are 0, and the next accepted pixel is column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel qualifier |
| pix_sof | input | 1 | Marks the accepted pixel as the first of a frame |
| pix_bit | input | 1 | Binary pixel value |
| res_vld | output | 1 | Result qualifier, one cycle after `pix_vld` |
| res_val | output | ceil(log2(IMG_W*IMG_H+1)) | Integral value for the pixel accepted in the previous cycle |

## Verification
The reference model stores every pixel of the current frame and sums the rectangle directly for each output, so it shares none of the line-store arithmetic. The stimulus covers the following cases:
- A random frame with scattered idle cycles checks the running sums and that holding is correct.
- An all-ones frame entered without a start marker separates correct automatic wrap and full-scale width from a wrong row count or truncation.
- A frame cut short by a fresh start marker shows that stale line contents are masked.
- Start markers sent on idle cycles show whether the marker is wrongly acted on when it is not qualified.

A checkerboard frame makes any column misalignment in the line store visible.

// File: rtl/bin_integral_pkg.sv
package bin_integral_pkg;
  // bits needed to hold the value n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
  // bits needed to index n items
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/iimg_raster_pos.sv
module iimg_raster_pos
  import bin_integral_pkg::*;
#(
  parameter int unsigned IMG_W = 320,
  parameter int unsigned IMG_H = 240,
  localparam int unsigned COL_W = idx_bits(IMG_W),
  localparam int unsigned ROW_W = idx_bits(IMG_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic             pix_sof,
  output logic [COL_W-1:0] cur_col,
  output logic             at_col0,
  output logic             at_row0
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d, cur_row;

  // effective position: a start marker forces the origin
  always_comb begin
    cur_col = pix_sof ? '0 : col_q;
    cur_row = pix_sof ? '0 : row_q;
    at_col0 = (cur_col == '0);
    at_row0 = (cur_row == '0);
    if (cur_col == LAST_COL) begin
      col_d = '0;
      row_d = (cur_row == LAST_ROW) ? '0 : cur_row + ROW_W'(1);
    end else begin
      col_d = cur_col + COL_W'(1);
      row_d = cur_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_vld) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // R5: position always stays within the frame
  assert_pos_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= LAST_COL) && (row_q <= LAST_ROW));
  // R3: idle cycles do not move the position
  assert_pos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> $stable(col_q) && $stable(row_q));
endmodule

// File: rtl/iimg_row_accum.sv
module iimg_row_accum
  import bin_integral_pkg::*;
#(
  parameter int unsigned IMG_W = 320,
  localparam int unsigned RS_W = bits_for(IMG_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_vld,
  input  logic            at_col0,
  input  logic            pix_bit,
  output logic [RS_W-1:0] rsum_now
);
  logic [RS_W-1:0] rsum_q;

  // count from row start including this pixel
  always_comb rsum_now = (at_col0 ? '0 : rsum_q) + RS_W'(pix_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsum_q <= '0;
    else if (pix_vld) rsum_q <= rsum_now;
  end

  // R1: row count restarts at column 0
  assert_row_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld && at_col0 |=> rsum_q == RS_W'($past(pix_bit)));
  // R6: a row never counts more than its width
  assert_row_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsum_q <= RS_W'(IMG_W));
endmodule

// File: rtl/iimg_line_store.sv
module iimg_line_store
  import bin_integral_pkg::*;
#(
  parameter int unsigned IMG_W = 320,
  parameter int unsigned VAL_W = 17,
  localparam int unsigned COL_W = idx_bits(IMG_W)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [COL_W-1:0] col,
  input  logic             first_row,
  input  logic [VAL_W-1:0] wr_val,
  output logic [VAL_W-1:0] above_val
);
  logic [VAL_W-1:0] line_mem [IMG_W];

  // lazy clear: first row of a frame sees zeros above
  always_comb above_val = first_row ? '0 : line_mem[col];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[col] <= wr_val;
  end
endmodule

// File: rtl/bin_integral_stream.sv
module bin_integral_stream
  import bin_integral_pkg::*;
#(
  parameter int unsigned IMG_W = 320,
  parameter int unsigned IMG_H = 240,
  localparam int unsigned VAL_W = bits_for(IMG_W * IMG_H),
  localparam int unsigned COL_W = idx_bits(IMG_W),
  localparam int unsigned RS_W  = bits_for(IMG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic             pix_sof,
  input  logic             pix_bit,
  output logic             res_vld,
  output logic [VAL_W-1:0] res_val
);
  localparam logic [VAL_W-1:0] FULL_CNT = VAL_W'(IMG_W * IMG_H);

  logic [COL_W-1:0] cur_col;
  logic             at_col0, at_row0;
  logic [RS_W-1:0]  rsum_now;
  logic [VAL_W-1:0] above_val, sum_now;
  logic             vld_q;
  logic [VAL_W-1:0] val_q;

  iimg_raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_sof(pix_sof),
    .cur_col(cur_col), .at_col0(at_col0), .at_row0(at_row0));

  iimg_row_accum #(.IMG_W(IMG_W)) u_row (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .at_col0(at_col0),
    .pix_bit(pix_bit), .rsum_now(rsum_now));

  iimg_line_store #(.IMG_W(IMG_W), .VAL_W(VAL_W)) u_line (
    .clk(clk), .wr_en(pix_vld), .col(cur_col), .first_row(at_row0),
    .wr_val(sum_now), .above_val(above_val));

  always_comb sum_now = above_val + VAL_W'(rsum_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      vld_q <= pix_vld;
      if (pix_vld) val_q <= sum_now;
    end
  end

  assign res_vld = vld_q;
  assign res_val = val_q;

  // R2: one-cycle valid latency
  assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> res_vld);
  assert_no_spurious_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> !res_vld);
  // R3: result held across idle cycles
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> $stable(res_val));
  // R6: never above the full-frame count
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_val <= FULL_CNT);
  // R1: integral never decreases along a row
  assert_row_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld && !at_col0 |=> res_val >= $past(res_val));
endmodule

// File: tb/tb_bin_integral_stream.sv
module tb_bin_integral_stream;
  localparam int W = 7;
  localparam int H = 5;
  localparam int VW = $clog2(W * H + 1);

  logic clk, rst_n, pix_vld, pix_sof, pix_bit;
  logic res_vld;
  logic [VW-1:0] res_val;

  bin_integral_stream #(.IMG_W(W), .IMG_H(H)) dut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_sof(pix_sof),
    .pix_bit(pix_bit), .res_vld(res_vld), .res_val(res_val));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int img [H][W];
  int cx = 0, cy = 0;
  int last_exp = 0;

  task automatic report(input string tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // one input cycle; model computes expected, checked after the edge
  task automatic step(input logic v, input logic s, input logic p, input string tag);
    int e;
    pix_vld = v; pix_sof = s; pix_bit = p;
    if (v) begin
      if (s) begin cx = 0; cy = 0; end
      img[cy][cx] = int'(p);
      e = 0;
      for (int r = 0; r <= cy; r++)
        for (int c = 0; c <= cx; c++) e += img[r][c];
      last_exp = e;
      cx++;
      if (cx == W) begin cx = 0; cy++; if (cy == H) cy = 0; end
    end
    @(posedge clk); #1;
    vectors++;
    if (res_vld !== v || int'(res_val) != last_exp) begin
      miscompares++;
      $display("FAIL %s: vld=%0b val=%0d expected vld=%0b val=%0d",
               tag, res_vld, res_val, v, last_exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      report("wd");
      $finish;
    end
  end

  initial begin
    pix_vld = 0; pix_sof = 0; pix_bit = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (res_vld !== 1'b0 || res_val !== '0) begin
      miscompares++;
      $display("FAIL R8: vld=%0b val=%0d expected vld=0 val=0", res_vld, res_val);
    end
    rst_n = 1;
    @(posedge clk); #1;
    step(0, 0, 0, "R8 idle after reset");
    // R8: first frame starts at origin without a marker; R1 random with R3 gaps
    for (int i = 0; i < W * H; i++) begin
      step(1, 0, 1'($urandom_range(0, 1)), "R1/R8 random frame");
      if (i % 5 == 2) step(0, 0, 1'($urandom_range(0, 1)), "R3 idle gap");
    end
    // R5 + R6: all-ones frame, no marker
    for (int i = 0; i < W * H; i++) step(1, 0, 1, "R5/R6 all ones");
    vectors++;
    if (int'(res_val) != W * H) begin
      miscompares++;
      $display("FAIL R6: val=%0d expected %0d", res_val, W * H);
    end
    // R4: partial frame then fresh marker mid-frame
    for (int i = 0; i < W * 2 + 3; i++) step(1, i == 0, 1'(i % 3 == 0), "R4 partial");
    for (int i = 0; i < W * H; i++) begin
      step(1, i == 0, 1'((i % W + i / W) % 2), "R4/R1 checkerboard after resync");
      // R7: marker on idle cycles must not move the position
      if (i % 4 == 1) step(0, 1, 1, "R7 unqualified marker");
    end
    // R5: wrap with a marker exactly at the frame boundary and a short tail
    for (int i = 0; i < W + 2; i++) step(1, i == 0, 1'(i % 2), "R5 boundary");
    step(0, 0, 0, "R2 final idle");
    done = 1;
    report("end");
    $finish;
  end
endmodule